// File: doc/BRIEF.md
# Partitionable Endpoint Freeze Filter

This block isolates faulty endpoints on a host bridge. It keeps a state table with one entry per partitionable endpoint (PE). Each entry holds two freeze flags: one gates MMIO traffic and the other gates DMA traffic, including MSIs. Every transaction arrives already tagged with its PE number. The filter looks up that PE's flags and either forwards the transaction one cycle later, or suppresses it. A suppressed store or MSI is discarded. A suppressed load is answered in its normal response slot with all-ones data, so the requester never waits for a reply that cannot come.

An error input freezes a PE. It sets both flags of that PE in one cycle and captures an error syndrome, but only when the entry was fully thawed. If the cause is a PCIe error message, the freeze also reaches every PE that has named the erring PE as its parent. Software uses a small command port to clear each flag on its own, to set a PE's parent link, and to read an entry back.

Top module: `pe_freeze_filter`

## Requirements
- R1: After reset, every entry has both flags clear and its link disabled, and none of fwd_valid, cpl_valid, drop_valid or rd_valid is asserted.
- R2: An error event (err_valid) sets both the MMIO and the DMA flag of err_pe at the same clock edge. A read issued on the next cycle shows both flags set.
- R3: Command CLR_MMIO (sw_op=0) clears only the MMIO flag, and CLR_DMA (sw_op=1) clears only the DMA flag, of sw_pe. READ (sw_op=3) returns the entry one cycle later on the rd_* outputs, showing the state before that edge.
- R4: If an error sets a flag of a PE on the same edge as a command clears that flag, the flag ends up set.
- R5: A store to a PE whose gating flag is set is not forwarded. Kind 1 (MMIO store) is gated by the MMIO flag and kind 3 (DMA write) by the DMA flag. One cycle later only drop_valid is asserted.
- R6: A load to a PE whose gating flag is set is not forwarded. Kind 0 (MMIO load) is gated by the MMIO flag and kind 2 (DMA read) by the DMA flag. One cycle later cpl_valid is asserted with cpl_pe equal to the request's PE and cpl_data all ones.
- R7: An MSI (kind 4) from a PE whose DMA flag is set is discarded, with only drop_valid asserted one cycle later.
- R8: A transaction whose gating flag is clear appears one cycle later on fwd_valid, fwd_kind, fwd_pe and fwd_data, unchanged. At most one of fwd_valid, cpl_valid and drop_valid is asserted in any cycle.
- R9: The syndrome is captured only when a freeze hits an entry whose two flags are both clear. It holds through later freezes until both flags have been cleared.
- R10: An error with err_msg=1 also freezes, with the same syndrome rule, every PE whose link is enabled and whose parent equals err_pe. Links are written by SET_LINK (sw_op=2) from sw_link_en and sw_parent.
- R11: An error with err_msg=0 freezes only err_pe. It does not reach linked children.
- R12: Each flag gates only its own traffic class. A PE with only the MMIO flag set still forwards DMA reads and MSIs, and a PE with only the DMA flag set still forwards MMIO stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction present |
| req_kind | input | 3 | 0 MMIO load, 1 MMIO store, 2 DMA read, 3 DMA write, 4 MSI |
| req_pe | input | PE_W | PE tag of the transaction |
| req_data | input | DATA_W | Store or payload data |
| fwd_valid | output | 1 | Forwarded transaction |
| fwd_kind | output | 3 | Forwarded kind |
| fwd_pe | output | PE_W | Forwarded PE tag |
| fwd_data | output | DATA_W | Forwarded data |
| cpl_valid | output | 1 | Synthesized completion for a blocked load |
| cpl_pe | output | PE_W | PE of the blocked load |
| cpl_data | output | DATA_W | All-ones completion data |
| drop_valid | output | 1 | A blocked store or MSI was discarded |
| err_valid | input | 1 | Freeze event |
| err_pe | input | PE_W | PE being frozen |
| err_msg | input | 1 | 1 when the cause is a PCIe error message (cascades) |
| err_synd | input | SYND_W | Error syndrome |
| sw_valid | input | 1 | Software command present |
| sw_op | input | 2 | 0 CLR_MMIO, 1 CLR_DMA, 2 SET_LINK, 3 READ |
| sw_pe | input | PE_W | Target PE of the command |
| sw_link_en | input | 1 | Link enable for SET_LINK |
| sw_parent | input | PE_W | Parent PE for SET_LINK |
| rd_valid | output | 1 | Read data valid |
| rd_mmio | output | 1 | MMIO freeze flag |
| rd_dma | output | 1 | DMA freeze flag |
| rd_synd | output | SYND_W | Captured syndrome |
| rd_link | output | 1 | Link enable |
| rd_parent | output | PE_W | Parent PE |

## Verification
The bench builds the block with NUM_PE=16, DATA_W=32 and SYND_W=8. With only 16 entries, a single test can set up a parent with two linked children, a second parent whose child must stay thawed, PEs with only one flag set, and a fully frozen PE, all side by side. The narrow data path keeps the all-ones completion word easy to see. The ordering cases covered are syndrome locking across repeated freezes, re-capture after a full thaw, and a set that collides with a clear.

// File: rtl/pe_ff_pkg.sv
package pe_ff_pkg;

  typedef enum logic [2:0] {
    K_MMIO_LD = 3'd0,
    K_MMIO_ST = 3'd1,
    K_DMA_RD  = 3'd2,
    K_DMA_WR  = 3'd3,
    K_MSI     = 3'd4
  } txn_kind_e;

  typedef enum logic [1:0] {
    OP_CLR_MMIO = 2'd0,
    OP_CLR_DMA  = 2'd1,
    OP_SET_LINK = 2'd2,
    OP_READ     = 2'd3
  } sw_op_e;

  typedef enum logic [1:0] {
    ACT_FWD  = 2'd0,
    ACT_CPL  = 2'd1,
    ACT_DROP = 2'd2
  } gate_act_e;

  // Loads need an answer; everything else can simply vanish.
  function automatic logic kind_is_load(input logic [2:0] k);
    return (k == K_MMIO_LD) || (k == K_DMA_RD);
  endfunction

  // Outbound MMIO kinds are gated by the MMIO flag, all inbound kinds by DMA.
  function automatic logic kind_uses_mmio(input logic [2:0] k);
    return (k == K_MMIO_LD) || (k == K_MMIO_ST);
  endfunction

  function automatic logic kind_known(input logic [2:0] k);
    return k <= K_MSI;
  endfunction

  function automatic gate_act_e gate_decide(input logic [2:0] k,
                                            input logic mmio_f,
                                            input logic dma_f);
    logic blocked;
    blocked = kind_uses_mmio(k) ? mmio_f : dma_f;
    if (!kind_known(k))  return ACT_DROP;
    if (!blocked)        return ACT_FWD;
    if (kind_is_load(k)) return ACT_CPL;
    return ACT_DROP;
  endfunction

endpackage

// File: rtl/pe_state_table.sv
module pe_state_table
  import pe_ff_pkg::*;
#(
  parameter int NUM_PE = 256,
  parameter int SYND_W = 8,
  localparam int PE_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           err_valid,
  input  logic [PE_W-1:0]                err_pe,
  input  logic                           err_msg,
  input  logic [SYND_W-1:0]              err_synd,
  input  logic                           sw_valid,
  input  logic [1:0]                     sw_op,
  input  logic [PE_W-1:0]                sw_pe,
  input  logic                           sw_link_en,
  input  logic [PE_W-1:0]                sw_parent,
  output logic [NUM_PE-1:0]              mmio_q,
  output logic [NUM_PE-1:0]              dma_q,
  output logic [NUM_PE-1:0][SYND_W-1:0]  synd_q,
  output logic [NUM_PE-1:0]              link_q,
  output logic [NUM_PE-1:0][PE_W-1:0]    parent_q,
  output logic [NUM_PE-1:0]              freeze_hit
);

  for (genvar i = 0; i < NUM_PE; i++) begin : g_ent
    logic direct, cascade, clr_m, clr_d, wr_link, thawed;

    assign direct  = err_valid && (err_pe == PE_W'(i));
    assign cascade = err_valid && err_msg && link_q[i] && (parent_q[i] == err_pe);
    assign freeze_hit[i] = direct || cascade;

    assign clr_m   = sw_valid && (sw_op == OP_CLR_MMIO) && (sw_pe == PE_W'(i));
    assign clr_d   = sw_valid && (sw_op == OP_CLR_DMA)  && (sw_pe == PE_W'(i));
    assign wr_link = sw_valid && (sw_op == OP_SET_LINK) && (sw_pe == PE_W'(i));
    assign thawed  = !mmio_q[i] && !dma_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mmio_q[i]   <= 1'b0;
        dma_q[i]    <= 1'b0;
        synd_q[i]   <= '0;
        link_q[i]   <= 1'b0;
        parent_q[i] <= '0;
      end else begin
        // a freeze outranks a clear arriving on the same edge
        if (freeze_hit[i])  mmio_q[i] <= 1'b1;
        else if (clr_m)     mmio_q[i] <= 1'b0;
        if (freeze_hit[i])  dma_q[i]  <= 1'b1;
        else if (clr_d)     dma_q[i]  <= 1'b0;
        if (freeze_hit[i] && thawed) synd_q[i] <= err_synd;
        if (wr_link) begin
          link_q[i]   <= sw_link_en;
          parent_q[i] <= sw_parent;
        end
      end
    end
  end

endmodule

// File: rtl/pe_txn_gate.sv
module pe_txn_gate
  import pe_ff_pkg::*;
#(
  parameter int NUM_PE = 256,
  parameter int DATA_W = 64,
  localparam int PE_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_kind,
  input  logic [PE_W-1:0]    req_pe,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [NUM_PE-1:0]  mmio_q,
  input  logic [NUM_PE-1:0]  dma_q,
  output logic               fwd_valid,
  output logic [2:0]         fwd_kind,
  output logic [PE_W-1:0]    fwd_pe,
  output logic [DATA_W-1:0]  fwd_data,
  output logic               cpl_valid,
  output logic [PE_W-1:0]    cpl_pe,
  output logic [DATA_W-1:0]  cpl_data,
  output logic               drop_valid
);

  gate_act_e act;

  always_comb begin
    act = gate_decide(req_kind, mmio_q[req_pe], dma_q[req_pe]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid  <= 1'b0;
      fwd_kind   <= '0;
      fwd_pe     <= '0;
      fwd_data   <= '0;
      cpl_valid  <= 1'b0;
      cpl_pe     <= '0;
      cpl_data   <= '0;
      drop_valid <= 1'b0;
    end else begin
      fwd_valid  <= req_valid && (act == ACT_FWD);
      cpl_valid  <= req_valid && (act == ACT_CPL);
      drop_valid <= req_valid && (act == ACT_DROP);
      if (req_valid && act == ACT_FWD) begin
        fwd_kind <= req_kind;
        fwd_pe   <= req_pe;
        fwd_data <= req_data;
      end
      if (req_valid && act == ACT_CPL) begin
        cpl_pe   <= req_pe;
        cpl_data <= '1;
      end
    end
  end

endmodule

// File: rtl/pe_status_read.sv
module pe_status_read
  import pe_ff_pkg::*;
#(
  parameter int NUM_PE = 256,
  parameter int SYND_W = 8,
  localparam int PE_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sw_valid,
  input  logic [1:0]                     sw_op,
  input  logic [PE_W-1:0]                sw_pe,
  input  logic [NUM_PE-1:0]              mmio_q,
  input  logic [NUM_PE-1:0]              dma_q,
  input  logic [NUM_PE-1:0][SYND_W-1:0]  synd_q,
  input  logic [NUM_PE-1:0]              link_q,
  input  logic [NUM_PE-1:0][PE_W-1:0]    parent_q,
  output logic                           rd_valid,
  output logic                           rd_mmio,
  output logic                           rd_dma,
  output logic [SYND_W-1:0]              rd_synd,
  output logic                           rd_link,
  output logic [PE_W-1:0]                rd_parent
);

  logic rd_req;
  assign rd_req = sw_valid && (sw_op == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_mmio   <= 1'b0;
      rd_dma    <= 1'b0;
      rd_synd   <= '0;
      rd_link   <= 1'b0;
      rd_parent <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_mmio   <= mmio_q[sw_pe];
        rd_dma    <= dma_q[sw_pe];
        rd_synd   <= synd_q[sw_pe];
        rd_link   <= link_q[sw_pe];
        rd_parent <= parent_q[sw_pe];
      end
    end
  end

endmodule

// File: rtl/pe_freeze_filter.sv
module pe_freeze_filter
  import pe_ff_pkg::*;
#(
  parameter int NUM_PE = 256,
  parameter int DATA_W = 64,
  parameter int SYND_W = 8,
  localparam int PE_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_kind,
  input  logic [PE_W-1:0]    req_pe,
  input  logic [DATA_W-1:0]  req_data,
  output logic               fwd_valid,
  output logic [2:0]         fwd_kind,
  output logic [PE_W-1:0]    fwd_pe,
  output logic [DATA_W-1:0]  fwd_data,
  output logic               cpl_valid,
  output logic [PE_W-1:0]    cpl_pe,
  output logic [DATA_W-1:0]  cpl_data,
  output logic               drop_valid,
  input  logic               err_valid,
  input  logic [PE_W-1:0]    err_pe,
  input  logic               err_msg,
  input  logic [SYND_W-1:0]  err_synd,
  input  logic               sw_valid,
  input  logic [1:0]         sw_op,
  input  logic [PE_W-1:0]    sw_pe,
  input  logic               sw_link_en,
  input  logic [PE_W-1:0]    sw_parent,
  output logic               rd_valid,
  output logic               rd_mmio,
  output logic               rd_dma,
  output logic [SYND_W-1:0]  rd_synd,
  output logic               rd_link,
  output logic [PE_W-1:0]    rd_parent
);

  logic [NUM_PE-1:0]             mmio_q;
  logic [NUM_PE-1:0]             dma_q;
  logic [NUM_PE-1:0][SYND_W-1:0] synd_q;
  logic [NUM_PE-1:0]             link_q;
  logic [NUM_PE-1:0][PE_W-1:0]   parent_q;
  logic [NUM_PE-1:0]             freeze_hit;

  pe_state_table #(.NUM_PE(NUM_PE), .SYND_W(SYND_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .err_valid(err_valid), .err_pe(err_pe), .err_msg(err_msg), .err_synd(err_synd),
    .sw_valid(sw_valid), .sw_op(sw_op), .sw_pe(sw_pe),
    .sw_link_en(sw_link_en), .sw_parent(sw_parent),
    .mmio_q(mmio_q), .dma_q(dma_q), .synd_q(synd_q),
    .link_q(link_q), .parent_q(parent_q), .freeze_hit(freeze_hit)
  );

  pe_txn_gate #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_pe(req_pe), .req_data(req_data),
    .mmio_q(mmio_q), .dma_q(dma_q),
    .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_pe(fwd_pe), .fwd_data(fwd_data),
    .cpl_valid(cpl_valid), .cpl_pe(cpl_pe), .cpl_data(cpl_data),
    .drop_valid(drop_valid)
  );

  pe_status_read #(.NUM_PE(NUM_PE), .SYND_W(SYND_W)) u_read (
    .clk(clk), .rst_n(rst_n),
    .sw_valid(sw_valid), .sw_op(sw_op), .sw_pe(sw_pe),
    .mmio_q(mmio_q), .dma_q(dma_q), .synd_q(synd_q),
    .link_q(link_q), .parent_q(parent_q),
    .rd_valid(rd_valid), .rd_mmio(rd_mmio), .rd_dma(rd_dma),
    .rd_synd(rd_synd), .rd_link(rd_link), .rd_parent(rd_parent)
  );

endmodule

// File: rtl/pe_freeze_filter_chk.sv
module pe_freeze_filter_chk
#(
  parameter int NUM_PE = 256,
  parameter int DATA_W = 64,
  parameter int SYND_W = 8,
  localparam int PE_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_valid,
  input logic [2:0]                     req_kind,
  input logic                           fwd_valid,
  input logic                           cpl_valid,
  input logic [DATA_W-1:0]              cpl_data,
  input logic                           drop_valid,
  input logic                           err_valid,
  input logic [PE_W-1:0]                err_pe,
  input logic                           sw_valid,
  input logic [1:0]                     sw_op,
  input logic [PE_W-1:0]                sw_pe,
  input logic [NUM_PE-1:0]              mmio_q,
  input logic [NUM_PE-1:0]              dma_q,
  input logic [NUM_PE-1:0][SYND_W-1:0]  synd_q
);

  // R2: the freeze event leaves both flags of the target set
  a_r2_both_set: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> (mmio_q[$past(err_pe)] && dma_q[$past(err_pe)]));

  // R4: a colliding clear loses to the freeze
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && sw_valid && sw_op == 2'd0 && sw_pe == err_pe) |=> mmio_q[$past(err_pe)]);

  // R6: synthesized completions always carry all ones
  a_r6_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (cpl_data == {DATA_W{1'b1}}));

  // R6: every load gets an answer in the next cycle
  a_r6_load_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 3'd0 || req_kind == 3'd2)) |=> (fwd_valid || cpl_valid));

  // R5: stores never produce a completion
  a_r5_store_no_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 3'd1 || req_kind == 3'd3)) |=> !cpl_valid);

  // R8: the three outcomes are mutually exclusive
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, cpl_valid, drop_valid}));

  // R9: a freeze on an already frozen entry keeps its syndrome
  a_r9_synd_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && (mmio_q[err_pe] || dma_q[err_pe]))
      |=> (synd_q[$past(err_pe)] == $past(synd_q[err_pe])));

endmodule

bind pe_freeze_filter pe_freeze_filter_chk #(
  .NUM_PE(NUM_PE), .DATA_W(DATA_W), .SYND_W(SYND_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .fwd_valid(fwd_valid), .cpl_valid(cpl_valid), .cpl_data(cpl_data),
  .drop_valid(drop_valid), .err_valid(err_valid), .err_pe(err_pe),
  .sw_valid(sw_valid), .sw_op(sw_op), .sw_pe(sw_pe),
  .mmio_q(mmio_q), .dma_q(dma_q), .synd_q(synd_q)
);

// File: tb/tb_pe_freeze_filter.sv
module tb_pe_freeze_filter;
  localparam int NUM_PE = 16;
  localparam int DATA_W = 32;
  localparam int SYND_W = 8;
  localparam int PE_W = $clog2(NUM_PE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid; logic [2:0] req_kind; logic [PE_W-1:0] req_pe; logic [DATA_W-1:0] req_data;
  logic fwd_valid; logic [2:0] fwd_kind; logic [PE_W-1:0] fwd_pe; logic [DATA_W-1:0] fwd_data;
  logic cpl_valid; logic [PE_W-1:0] cpl_pe; logic [DATA_W-1:0] cpl_data; logic drop_valid;
  logic err_valid; logic [PE_W-1:0] err_pe; logic err_msg; logic [SYND_W-1:0] err_synd;
  logic sw_valid; logic [1:0] sw_op; logic [PE_W-1:0] sw_pe; logic sw_link_en; logic [PE_W-1:0] sw_parent;
  logic rd_valid, rd_mmio, rd_dma, rd_link; logic [SYND_W-1:0] rd_synd; logic [PE_W-1:0] rd_parent;

  pe_freeze_filter #(.NUM_PE(NUM_PE), .DATA_W(DATA_W), .SYND_W(SYND_W)) dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    req_valid = 0; req_kind = 0; req_pe = 0; req_data = 0;
    err_valid = 0; err_pe = 0; err_msg = 0; err_synd = 0;
    sw_valid = 0; sw_op = 0; sw_pe = 0; sw_link_en = 0; sw_parent = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic raise(input int pe, input bit msg, input int synd);
    err_valid = 1; err_pe = PE_W'(pe); err_msg = msg; err_synd = SYND_W'(synd);
    step(); clear_in();
  endtask

  task automatic cmd(input int op, input int pe, input bit en, input int par);
    sw_valid = 1; sw_op = 2'(op); sw_pe = PE_W'(pe); sw_link_en = en; sw_parent = PE_W'(par);
    step(); clear_in();
  endtask

  // read PE; rd_* valid at the sampling point after the edge
  task automatic rd(input int pe);
    cmd(3, pe, 0, 0);
  endtask

  // outcome codes: 0 forwarded, 1 completed with ones, 2 dropped
  typedef struct packed { logic [2:0] kind; logic [3:0] pe; logic [1:0] res; } vec_t;
  localparam vec_t VECS [16] = '{
    '{3'd0, 4'd1, 2'd0}, '{3'd1, 4'd1, 2'd0}, '{3'd3, 4'd1, 2'd0}, '{3'd4, 4'd1, 2'd0},
    '{3'd0, 4'd9, 2'd1}, '{3'd1, 4'd9, 2'd2}, '{3'd2, 4'd9, 2'd1}, '{3'd3, 4'd9, 2'd2},
    '{3'd4, 4'd9, 2'd2}, '{3'd0, 4'd2, 2'd1}, '{3'd2, 4'd2, 2'd0}, '{3'd4, 4'd2, 2'd0},
    '{3'd1, 4'd3, 2'd0}, '{3'd3, 4'd3, 2'd2}, '{3'd4, 4'd3, 2'd2}, '{3'd2, 4'd1, 2'd0}
  };

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 fwd", fwd_valid, 0); chk("R1 cpl", cpl_valid, 0);
    chk("R1 drop", drop_valid, 0); chk("R1 rd", rd_valid, 0);
    rst_n = 1; @(negedge clk);
    rd(3); chk("R1 rd_valid", rd_valid, 1); chk("R1 mmio", rd_mmio, 0);
    chk("R1 dma", rd_dma, 0); chk("R1 link", rd_link, 0);

    // links: 5,6 -> 4 ; 7 -> 8
    cmd(2, 5, 1, 4); cmd(2, 6, 1, 4); cmd(2, 7, 1, 8);
    rd(6); chk("R10 link", rd_link, 1); chk("R10 parent", rd_parent, 4);

    // R2/R10: message error cascades to children
    raise(4, 1, 8'h3C);
    rd(4); chk("R2 mmio", rd_mmio, 1); chk("R2 dma", rd_dma, 1); chk("R9 synd", rd_synd, 8'h3C);
    rd(5); chk("R10 child mmio", rd_mmio, 1); chk("R10 child dma", rd_dma, 1);
    chk("R10 child synd", rd_synd, 8'h3C);
    rd(6); chk("R10 child2 dma", rd_dma, 1);
    rd(7); chk("R10 unrelated", rd_mmio, 0);

    // R11: other cause does not cascade
    raise(8, 0, 8'h11);
    rd(8); chk("R11 self", rd_dma, 1);
    rd(7); chk("R11 child mmio", rd_mmio, 0); chk("R11 child dma", rd_dma, 0);

    // R9: locked syndrome
    raise(4, 0, 8'h55);
    rd(4); chk("R9 locked", rd_synd, 8'h3C);
    // R3: independent clears
    cmd(0, 4, 0, 0);
    rd(4); chk("R3 mmio clr", rd_mmio, 0); chk("R3 dma kept", rd_dma, 1);
    raise(4, 0, 8'h66);
    rd(4); chk("R9 partial thaw", rd_synd, 8'h3C);
    cmd(0, 4, 0, 0); cmd(1, 4, 0, 0);
    rd(4); chk("R3 both clr mmio", rd_mmio, 0); chk("R3 both clr dma", rd_dma, 0);
    raise(4, 0, 8'h77);
    rd(4); chk("R9 recapture", rd_synd, 8'h77);

    // R4: freeze collides with clear
    err_valid = 1; err_pe = 10; err_synd = 8'h22;
    sw_valid = 1; sw_op = 0; sw_pe = 10;
    step(); clear_in();
    rd(10); chk("R4 set wins", rd_mmio, 1);

    // setup for table: 2 mmio-only, 3 dma-only, 9 both
    raise(2, 0, 1); cmd(1, 2, 0, 0);
    raise(3, 0, 2); cmd(0, 3, 0, 0);
    raise(9, 0, 3);

    // R5 R6 R7 R8 R12 vector walk
    for (int i = 0; i < 16; i++) begin
      logic [DATA_W-1:0] d;
      d = DATA_W'(32'hA5000000 + i);
      req_valid = 1; req_kind = VECS[i].kind; req_pe = VECS[i].pe; req_data = d;
      step(); clear_in();
      chk($sformatf("R8 R12 fwd v%0d", i), fwd_valid, VECS[i].res == 0);
      chk($sformatf("R6 cpl v%0d", i), cpl_valid, VECS[i].res == 1);
      chk($sformatf("R5 R7 drop v%0d", i), drop_valid, VECS[i].res == 2);
      if (VECS[i].res == 0) begin
        chk($sformatf("R8 data v%0d", i), fwd_data, d);
        chk($sformatf("R8 kind v%0d", i), fwd_kind, VECS[i].kind);
        chk($sformatf("R8 pe v%0d", i), fwd_pe, VECS[i].pe);
      end
      if (VECS[i].res == 1) begin
        chk($sformatf("R6 ones v%0d", i), cpl_data, {DATA_W{1'b1}});
        chk($sformatf("R6 pe v%0d", i), cpl_pe, VECS[i].pe);
      end
    end

    // R8: outputs idle with no request
    step(); chk("R8 idle", {fwd_valid, cpl_valid, drop_valid}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule